// File: doc/BRIEF.md
# SPI Serial EEPROM Command Engine

This block is the command side of a small byte-wide nonvolatile memory that sits behind a mode-0 SPI slave port. A host selects it by pulling `cs_n` low and shifts in an 8-bit opcode, most significant bit first. Depending on the opcode, it then sends a 16-bit address and data, or it clocks data back out. The memory is a 2048-byte register array that stands in for the cell array. Only the low 11 address bits are decoded, and writes are grouped into 32-byte pages.

The serial inputs are resynchronised into the system clock domain, with edge detection on SCK and chip select. A controller state machine handles the frame. Its states are ST_IDLE (deselected), ST_OPC (collecting the opcode), ST_ADDR (collecting the address), ST_RDAT (streaming array bytes), ST_WDAT (filling the page buffer), ST_SRIN (collecting a status byte), ST_SROUT (streaming the status byte), ST_HOLD (one full command byte received, waiting for deselect) and ST_SKIP (frame ignored until deselect).

Its transitions are as follows:
- A select moves ST_IDLE to ST_OPC.
- A complete opcode moves ST_OPC to ST_ADDR, ST_SROUT, ST_SRIN, ST_HOLD or ST_SKIP.
- The sixteenth address bit moves ST_ADDR to ST_RDAT or ST_WDAT.
- A complete status byte moves ST_SRIN to ST_HOLD.
- Any extra bit moves ST_HOLD to ST_SKIP.
- Deselect returns every state to ST_IDLE.

A nonvolatile update starts only at deselect, and only when the frame stopped on a legal bit count. A storage unit then copies the buffered page, or the new status bits, during a write cycle of programmable length. Throughout that cycle the busy flag is reported.

Top module: `spi_eeprom_engine`

## Requirements
- R1: SI is sampled on rising SCK and SO changes only after falling SCK, both MSB first. `so_oe` is high only while the device is selected and in the ST_RDAT or ST_SROUT phase, and is low whenever `cs_n` is high.
- R2: READ (0x03) followed by a 16-bit address streams bytes from consecutive addresses. Address bits above bit 10 are ignored.
- R3: A sequential read past address 0x7FF continues at 0x000.
- R4: WRITE (0x02) followed by an address and one or more whole data bytes programs those bytes and starts a write cycle, provided the write latch is set and chip select rises right after bit 0 of a data byte.
- R5: During a WRITE, the byte offset wraps from 31 to 0 inside the same 32-byte page. A later byte at the same offset overwrites the earlier one.
- R6: If chip select rises in the middle of a data byte, or before any data byte, the write is cancelled. No cycle starts and the memory is unchanged.
- R7: Opcode 0x06 sets the write latch, 0x00 sets the flag bit and 0x04 clears both. Each acts only when the frame ends exactly after its 8 bits; a longer or shorter frame changes nothing.
- R8: RDSR (0x05) returns the status byte repeatedly for as long as SCK runs, and is honoured during a write cycle. The status byte holds the cycle-busy flag in bit 0, the write latch in bit 1, the flag bit in bit 6, and the stored configuration bits 7:2.
- R9: While a write cycle runs, every opcode other than RDSR is ignored for the rest of its frame.
- R10: WRSR (0x01) followed by one byte, ended on the byte boundary with the write latch set, runs a write cycle. At the end of that cycle, status bits 7:2 take the byte's bits 7:2; bits 1:0 of the byte are discarded.
- R11: A write or status write requested while the write latch is clear is ignored. The end of each write cycle clears the write latch.
- R12: After reset, the status byte reads 0x00, every array byte reads 0xFF and `so_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than SCK |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low chip select |
| si | input | 1 | Serial data from the host |
| so | output | 1 | Serial data to the host |
| so_oe | output | 1 | High when `so` should drive the line; low means high impedance |

## Verification
The hardest case to reach from the pins is an opcode arriving while a write cycle is running, because the cycle begins only at deselect and its length is set by a counter. The bench therefore lengthens the cycle through the parameter. Right after a committed WRITE, it issues a flag-set command and a READ frame while the cycle is still counting, and confirms that the output stays undriven. After the cycle ends, it reads back the status byte to show that the flag never changed. The aborted-write cases are built by stopping a frame three bits into a data byte, or straight after the address, and then checking both the status byte and the target location.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;

    typedef enum logic [7:0] {
        OP_SETFLAG = 8'h00,
        OP_WRSR    = 8'h01,
        OP_WRITE   = 8'h02,
        OP_READ    = 8'h03,
        OP_CLRWEL  = 8'h04,
        OP_RDSR    = 8'h05,
        OP_SETWEL  = 8'h06
    } opcode_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_OPC,
        ST_ADDR,
        ST_RDAT,
        ST_WDAT,
        ST_SRIN,
        ST_SROUT,
        ST_HOLD,
        ST_SKIP
    } state_e;

endpackage

// File: rtl/spi_ee_sync.sv
// Brings SCK, chip select and SI into the clk domain and derives edge strobes.
module spi_ee_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    input  logic si,
    output logic sck_rise,
    output logic sck_fall,
    output logic sel,
    output logic sel_end,
    output logic si_s
);
    logic [2:0] sck_p;
    logic [2:0] cs_p;
    logic [1:0] si_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_p <= 3'b000;
            cs_p  <= 3'b111;
            si_p  <= 2'b00;
        end else begin
            sck_p <= {sck_p[1:0], sck};
            cs_p  <= {cs_p[1:0], cs_n};
            si_p  <= {si_p[0], si};
        end
    end

    always_comb begin
        sck_rise = sck_p[1] & ~sck_p[2];
        sck_fall = ~sck_p[1] & sck_p[2];
        sel      = ~cs_p[1];
        sel_end  = cs_p[1] & ~cs_p[2];
        si_s     = si_p[1];
    end
endmodule

// File: rtl/spi_ee_ctrl.sv
// Frame state machine: shifting, opcode decode, address counters, output shifter.
module spi_ee_ctrl
    import spi_ee_pkg::*;
#(
    parameter int AW = 11,
    parameter int PB = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sck_rise,
    input  logic          sck_fall,
    input  logic          sel,
    input  logic          sel_end,
    input  logic          si_s,
    input  logic          busy,
    input  logic [7:0]    status,
    input  logic [7:0]    rd_data,
    output logic [AW-1:0] rd_addr,
    output logic          buf_clr,
    output logic          buf_we,
    output logic [PB-1:0] buf_off,
    output logic [7:0]    buf_data,
    output logic [AW-PB-1:0] page_sel,
    output logic          req_page,
    output logic          req_sr,
    output logic [5:0]    sr_data,
    output logic          set_wel,
    output logic          clr_wel,
    output logic          set_flag,
    output logic          so,
    output logic          so_oe
);
    state_e state, state_nx;

    logic [6:0]       shreg;
    logic [7:0]       rx_nx;
    logic [2:0]       bitn;
    logic [3:0]       abit;
    logic [7:0]       opc;
    logic [AW-1:0]    addr;
    logic [AW-1:0]    addr_nx;
    logic [PB-1:0]    woff;
    logic [AW-PB-1:0] page_q;
    logic             got_byte;
    logic [5:0]       sr_q;
    logic [7:0]       tx_byte;
    logic [2:0]       tx_idx;
    logic             ld_pend;
    logic             so_q;
    logic             byte_in;

    assign rx_nx   = {shreg, si_s};
    assign addr_nx = {addr[AW-2:0], si_s};
    assign byte_in = sck_rise && (bitn == 3'd7);

    // next-state logic
    always_comb begin
        state_nx = state;
        if (!sel) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: state_nx = ST_OPC;
                ST_OPC: begin
                    if (byte_in) begin
                        if (busy && rx_nx != OP_RDSR) begin
                            state_nx = ST_SKIP;
                        end else begin
                            case (rx_nx)
                                OP_READ, OP_WRITE:                 state_nx = ST_ADDR;
                                OP_RDSR:                           state_nx = ST_SROUT;
                                OP_WRSR:                           state_nx = ST_SRIN;
                                OP_SETWEL, OP_CLRWEL, OP_SETFLAG:  state_nx = ST_HOLD;
                                default:                           state_nx = ST_SKIP;
                            endcase
                        end
                    end
                end
                ST_ADDR:  if (sck_rise && abit == 4'd15)
                              state_nx = (opc == OP_READ) ? ST_RDAT : ST_WDAT;
                ST_SRIN:  if (byte_in) state_nx = ST_HOLD;
                ST_HOLD:  if (sck_rise) state_nx = ST_SKIP;
                ST_RDAT, ST_WDAT, ST_SROUT, ST_SKIP: state_nx = state;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg    <= '0;
            bitn     <= '0;
            abit     <= '0;
            opc      <= '0;
            addr     <= '0;
            woff     <= '0;
            page_q   <= '0;
            got_byte <= 1'b0;
            sr_q     <= '0;
            tx_byte  <= '0;
            tx_idx   <= '0;
            ld_pend  <= 1'b0;
            so_q     <= 1'b0;
        end else begin
            ld_pend <= 1'b0;
            if (state == ST_IDLE) begin
                bitn     <= '0;
                abit     <= '0;
                got_byte <= 1'b0;
                tx_idx   <= '0;
            end
            if (sck_rise) begin
                shreg <= rx_nx[6:0];
                bitn  <= bitn + 3'd1;
                case (state)
                    ST_OPC: if (bitn == 3'd7) begin
                        opc     <= rx_nx;
                        ld_pend <= (rx_nx == OP_RDSR);
                    end
                    ST_ADDR: begin
                        addr <= addr_nx;
                        abit <= abit + 4'd1;
                        if (abit == 4'd15) begin
                            woff    <= addr_nx[PB-1:0];
                            page_q  <= addr_nx[AW-1:PB];
                            ld_pend <= 1'b1;
                        end
                    end
                    ST_WDAT: if (bitn == 3'd7) begin
                        woff     <= woff + 1'b1;
                        got_byte <= 1'b1;
                    end
                    ST_SRIN: if (bitn == 3'd7) sr_q <= rx_nx[7:2];
                    default: ;
                endcase
            end
            if (sck_fall && (state == ST_RDAT || state == ST_SROUT)) begin
                so_q   <= tx_byte[~tx_idx];
                tx_idx <= tx_idx + 3'd1;
                if (tx_idx == 3'd7) begin
                    ld_pend <= 1'b1;
                    if (state == ST_RDAT) addr <= addr + 1'b1;
                end
            end
            if (ld_pend) tx_byte <= (state == ST_SROUT) ? status : rd_data;
        end
    end

    // outputs and request strobes
    always_comb begin
        so       = so_q;
        so_oe    = sel && (state == ST_RDAT || state == ST_SROUT);
        rd_addr  = addr;
        buf_off  = woff;
        buf_data = rx_nx;
        page_sel = page_q;
        sr_data  = sr_q;
        buf_we   = byte_in && (state == ST_WDAT);
        buf_clr  = byte_in && (state == ST_OPC) && !busy && (rx_nx == OP_WRITE);
        req_page = sel_end && (state == ST_WDAT) && (bitn == 3'd0) && got_byte;
        req_sr   = sel_end && (state == ST_HOLD) && (opc == OP_WRSR);
        set_wel  = sel_end && (state == ST_HOLD) && (opc == OP_SETWEL);
        clr_wel  = sel_end && (state == ST_HOLD) && (opc == OP_CLRWEL);
        set_flag = sel_end && (state == ST_HOLD) && (opc == OP_SETFLAG);
    end

    // R1: output bit moves only after a falling SCK edge
    a_r1_so_changes_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(so_q) |-> $past(sck_fall));

    // R6: commits are requested only at deselect
    a_r6_commit_at_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        (req_page || req_sr) |-> !sel);
endmodule

// File: rtl/spi_ee_store.sv
// Array stand-in, page buffer, status bits and write-cycle timer.
module spi_ee_store #(
    parameter int AW        = 11,
    parameter int PB        = 5,
    parameter int WR_CYCLES = 200   // must be at least 2**PB
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    rd_addr,
    input  logic             buf_clr,
    input  logic             buf_we,
    input  logic [PB-1:0]    buf_off,
    input  logic [7:0]       buf_data,
    input  logic [AW-PB-1:0] page_sel,
    input  logic             req_page,
    input  logic             req_sr,
    input  logic [5:0]       sr_data,
    input  logic             set_wel,
    input  logic             clr_wel,
    input  logic             set_flag,
    output logic [7:0]       rd_data,
    output logic [7:0]       status,
    output logic             busy
);
    localparam int NBYTES = 2 ** AW;
    localparam int PAGE   = 2 ** PB;
    localparam int TW     = $clog2(WR_CYCLES);
    localparam logic [TW-1:0] PAGE_T = TW'(PAGE);
    localparam logic [TW-1:0] LAST_T = TW'(WR_CYCLES - 1);
    localparam int FLAG_IDX = 4;   // status bit 6 within cfg[5:0]

    logic [7:0]       mem  [NBYTES];
    logic [7:0]       pbuf [PAGE];
    logic [PAGE-1:0]  pvalid;
    logic [AW-PB-1:0] pbase;
    logic [TW-1:0]    timer;
    logic             is_sr;
    logic [5:0]       sr_pend;
    logic [5:0]       cfg;
    logic             wel;
    logic [PB-1:0]    slot;

    assign slot = timer[PB-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NBYTES; i++) mem[i] <= 8'hFF;
            for (int j = 0; j < PAGE; j++)   pbuf[j] <= 8'h00;
            pvalid  <= '0;
            pbase   <= '0;
            timer   <= '0;
            is_sr   <= 1'b0;
            sr_pend <= '0;
            cfg     <= '0;
            wel     <= 1'b0;
            busy    <= 1'b0;
        end else begin
            if (buf_clr) pvalid <= '0;
            if (buf_we) begin
                pbuf[buf_off]   <= buf_data;
                pvalid[buf_off] <= 1'b1;
            end
            if (set_wel)  wel <= 1'b1;
            if (set_flag) cfg[FLAG_IDX] <= 1'b1;
            if (clr_wel) begin
                wel           <= 1'b0;
                cfg[FLAG_IDX] <= 1'b0;
            end
            if (!busy && wel && req_page) begin
                busy  <= 1'b1;
                timer <= '0;
                is_sr <= 1'b0;
                pbase <= page_sel;
            end
            if (!busy && wel && req_sr) begin
                busy    <= 1'b1;
                timer   <= '0;
                is_sr   <= 1'b1;
                sr_pend <= sr_data;
            end
            if (busy) begin
                timer <= timer + 1'b1;
                if (!is_sr && timer < PAGE_T && pvalid[slot])
                    mem[{pbase, slot}] <= pbuf[slot];
                if (timer == LAST_T) begin
                    busy <= 1'b0;
                    wel  <= 1'b0;
                    if (is_sr) cfg <= sr_pend;
                end
            end
        end
    end

    assign rd_data = mem[rd_addr];
    assign status  = {cfg, wel, busy};

    // R11: a cycle starts only with the write latch set
    a_r11_latch_before_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wel));

    // R11: the latch is clear once a cycle ends
    a_r11_latch_clear_after: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !wel);

    // R9: no page-buffer fill and no command request while a cycle runs
    a_r9_quiet_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_we || set_wel || clr_wel || set_flag || req_sr) |-> !busy);

    // R7: at most one command strobe per cycle
    a_r7_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({req_page, req_sr, set_wel, clr_wel, set_flag}));
endmodule

// File: rtl/spi_eeprom_engine.sv
module spi_eeprom_engine #(
    parameter int AW        = 11,
    parameter int PB        = 5,
    parameter int WR_CYCLES = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    input  logic si,
    output logic so,
    output logic so_oe
);
    logic sck_rise, sck_fall, sel, sel_end, si_s;
    logic busy, buf_clr, buf_we, req_page, req_sr, set_wel, clr_wel, set_flag;
    logic [7:0]       status, rd_data, buf_data;
    logic [AW-1:0]    rd_addr;
    logic [PB-1:0]    buf_off;
    logic [AW-PB-1:0] page_sel;
    logic [5:0]       sr_data;

    spi_ee_sync u_sync (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .sel(sel),
        .sel_end(sel_end), .si_s(si_s)
    );

    spi_ee_ctrl #(.AW(AW), .PB(PB)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .sck_rise(sck_rise), .sck_fall(sck_fall),
        .sel(sel), .sel_end(sel_end), .si_s(si_s), .busy(busy),
        .status(status), .rd_data(rd_data), .rd_addr(rd_addr),
        .buf_clr(buf_clr), .buf_we(buf_we), .buf_off(buf_off),
        .buf_data(buf_data), .page_sel(page_sel), .req_page(req_page),
        .req_sr(req_sr), .sr_data(sr_data), .set_wel(set_wel),
        .clr_wel(clr_wel), .set_flag(set_flag), .so(so), .so_oe(so_oe)
    );

    spi_ee_store #(.AW(AW), .PB(PB), .WR_CYCLES(WR_CYCLES)) u_store (
        .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .buf_clr(buf_clr),
        .buf_we(buf_we), .buf_off(buf_off), .buf_data(buf_data),
        .page_sel(page_sel), .req_page(req_page), .req_sr(req_sr),
        .sr_data(sr_data), .set_wel(set_wel), .clr_wel(clr_wel),
        .set_flag(set_flag), .rd_data(rd_data), .status(status), .busy(busy)
    );
endmodule

// File: tb/spi_eeprom_engine_bench.sv
module spi_eeprom_engine_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0;
    logic cs_n = 1'b1;
    logic si = 1'b0;
    logic so, so_oe;

    localparam int HALF = 6;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    spi_eeprom_engine #(.WR_CYCLES(600)) u_spi_eeprom_engine (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
        .so(so), .so_oe(so_oe)
    );

    // {opcode, bits sent, expected status afterwards}
    localparam logic [19:0] TBL [8] = '{
        {8'h06, 4'd8, 8'h02},
        {8'h00, 4'd8, 8'h42},
        {8'h04, 4'd8, 8'h00},
        {8'h06, 4'd9, 8'h00},
        {8'h06, 4'd7, 8'h00},
        {8'h00, 4'd8, 8'h40},
        {8'h06, 4'd8, 8'h42},
        {8'h04, 4'd8, 8'h00}
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic xbit(input logic b, output logic r);
        si = b;
        tick(HALF);
        r = so;
        sck = 1'b1;
        tick(HALF);
        sck = 1'b0;
    endtask

    task automatic xbyte(input logic [7:0] t, output logic [7:0] r);
        for (int i = 7; i >= 0; i--) begin
            logic b;
            xbit(t[i], b);
            r[i] = b;
        end
    endtask

    task automatic sel_on();
        cs_n = 1'b0;
        tick(HALF);
    endtask

    task automatic sel_off();
        tick(HALF);
        cs_n = 1'b1;
        tick(2 * HALF + 4);
    endtask

    task automatic cmd1(input logic [7:0] op);
        logic [7:0] d;
        sel_on();
        xbyte(op, d);
        sel_off();
    endtask

    task automatic rdsr(output logic [7:0] s);
        logic [7:0] d;
        sel_on();
        xbyte(8'h05, d);
        xbyte(8'h00, s);
        sel_off();
    endtask

    task automatic rd2(input logic [15:0] a, output logic [7:0] b0, output logic [7:0] b1);
        logic [7:0] d;
        sel_on();
        xbyte(8'h03, d);
        xbyte(a[15:8], d);
        xbyte(a[7:0], d);
        xbyte(8'h00, b0);
        xbyte(8'h00, b1);
        sel_off();
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] data, input int n);
        logic [7:0] d;
        sel_on();
        xbyte(8'h02, d);
        xbyte(a[15:8], d);
        xbyte(a[7:0], d);
        for (int i = 0; i < n; i++) xbyte(data[31-8*i -: 8], d);
        sel_off();
    endtask

    task automatic wait_idle();
        logic [7:0] s;
        for (int k = 0; k < 20; k++) begin
            rdsr(s);
            if (!s[0]) break;
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] s, s2, b0, b1, d;
        tick(5);
        rst_n = 1'b1;
        tick(5);

        // R12: reset state
        chk("R12 so_oe after reset", {31'd0, so_oe}, 32'd0);
        rdsr(s);
        chk("R12 status after reset", {24'd0, s}, 32'h00);
        rd2(16'h0000, b0, b1);
        chk("R12 erased byte", {24'd0, b0}, 32'hFF);

        // R7: single-byte command table
        for (int v = 0; v < 8; v++) begin
            logic r;
            sel_on();
            for (int i = 0; i < int'(TBL[v][11:8]); i++)
                xbit((i < 8) ? TBL[v][19-i] : 1'b0, r);
            sel_off();
            rdsr(s);
            chk($sformatf("R7 table entry %0d", v), {24'd0, s}, {24'd0, TBL[v][7:0]});
        end

        // R4 / R8: page write then status while busy
        cmd1(8'h06);
        wr(16'h0010, 32'hA1A2A300, 3);
        rdsr(s);
        chk("R8 status during cycle", {24'd0, s}, 32'h03);
        wait_idle();
        rdsr(s);
        chk("R11 latch cleared after cycle", {24'd0, s}, 32'h00);
        rd2(16'h0010, b0, b1);
        chk("R4 first byte", {24'd0, b0}, 32'hA1);
        chk("R4 second byte", {24'd0, b1}, 32'hA2);

        // R1: output enable follows the read phase
        sel_on();
        xbyte(8'h03, d);
        xbyte(8'h00, d);
        xbyte(8'h12, d);
        tick(2);
        chk("R1 so_oe in read phase", {31'd0, so_oe}, 32'd1);
        xbyte(8'h00, b0);
        chk("R1 serial byte out", {24'd0, b0}, 32'hA3);
        sel_off();
        chk("R1 so_oe after deselect", {31'd0, so_oe}, 32'd0);

        // R2: upper address bits ignored
        rd2(16'hF810, b0, b1);
        chk("R2 aliased read byte 0", {24'd0, b0}, 32'hA1);
        chk("R2 aliased read byte 1", {24'd0, b1}, 32'hA2);

        // R9: commands during a cycle are ignored
        cmd1(8'h06);
        wr(16'h0100, 32'h55000000, 1);
        cmd1(8'h00);
        sel_on();
        xbyte(8'h03, d);
        xbyte(8'h00, d);
        xbyte(8'h10, d);
        tick(2);
        chk("R9 READ ignored while busy", {31'd0, so_oe}, 32'd0);
        sel_off();
        wait_idle();
        rdsr(s);
        chk("R9 flag untouched by busy SFLB", {24'd0, s}, 32'h00);
        rd2(16'h0100, b0, b1);
        chk("R4 byte after busy frame", {24'd0, b0}, 32'h55);

        // R5: in-page wrap
        cmd1(8'h06);
        wr(16'h003E, 32'h11223344, 4);
        wait_idle();
        rd2(16'h003E, b0, b1);
        chk("R5 offset 30", {24'd0, b0}, 32'h11);
        chk("R5 offset 31", {24'd0, b1}, 32'h22);
        rd2(16'h0020, b0, b1);
        chk("R5 wrapped offset 0", {24'd0, b0}, 32'h33);
        chk("R5 wrapped offset 1", {24'd0, b1}, 32'h44);

        // R3: read wraps over the top address
        cmd1(8'h06);
        wr(16'h07FF, 32'h5A000000, 1);
        wait_idle();
        cmd1(8'h06);
        wr(16'h0000, 32'hC3000000, 1);
        wait_idle();
        rd2(16'h07FF, b0, b1);
        chk("R3 top byte", {24'd0, b0}, 32'h5A);
        chk("R3 wrapped byte", {24'd0, b1}, 32'hC3);

        // R6: aborted writes
        cmd1(8'h06);
        sel_on();
        xbyte(8'h02, d);
        xbyte(8'h02, d);
        xbyte(8'h00, d);
        xbyte(8'h99, d);
        for (int i = 0; i < 3; i++) begin
            logic r;
            xbit(1'b0, r);
        end
        sel_off();
        rdsr(s);
        chk("R6 mid-byte abort no cycle", {24'd0, s}, 32'h02);
        rd2(16'h0200, b0, b1);
        chk("R6 mid-byte abort memory", {24'd0, b0}, 32'hFF);
        wr(16'h0200, 32'h0, 0);
        rdsr(s);
        chk("R6 address-only abort", {24'd0, s}, 32'h02);

        // R11: write without latch
        cmd1(8'h04);
        wr(16'h0300, 32'h77000000, 1);
        rdsr(s);
        chk("R11 no cycle without latch", {24'd0, s}, 32'h00);
        rd2(16'h0300, b0, b1);
        chk("R11 memory unchanged", {24'd0, b0}, 32'hFF);

        // R10: status write
        cmd1(8'h06);
        sel_on();
        xbyte(8'h01, d);
        xbyte(8'h8F, d);
        sel_off();
        rdsr(s);
        chk("R10 status cycle running", {24'd0, s}, 32'h03);
        wait_idle();
        sel_on();
        xbyte(8'h05, d);
        xbyte(8'h00, s);
        xbyte(8'h00, s2);
        sel_off();
        chk("R10 stored bits 7:2", {24'd0, s}, 32'h8C);
        chk("R8 status repeats", {24'd0, s2}, 32'h8C);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule